// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block translates a virtual address into a physical address by walking in-memory translation tables one entry at a time. A request is a single-cycle start pulse carrying the virtual address, the kind of access being attempted (write, user, execute), the table root register and the paging mode flags. The walker then issues one read per table level over a simple request/response port. It checks each returned entry and either finishes with a physical address or stops with a fault.

Three table formats are handled by one state machine. The first is a two-level format with 4-byte entries and 10-bit indices. The second is a three-level format with 8-byte entries, whose top level is a small pointer table. The third is a four-level format with 8-byte entries and 9-bit indices. A walk may also stop one level early on a large-page entry: 4 MB in the two-level format, where the entry carries extra high address bits, and 2 MB in the 8-byte formats. When paging is off, the address passes straight through without any reads. Each walk finishes with a one-cycle done pulse. The success flag, the physical address and a small error code are then held until the next walk is accepted.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled at start, done rises on the next cycle with ok high, pa equal to the zero-extended virtual address, err zero, and no read issued.
- R2: A walk issues at most 2 reads without the wide-entry flag, 3 with the wide-entry flag and long mode clear, and 4 with both set (long mode is ignored when the wide-entry flag is clear). It issues exactly that many reads when no entry faults or ends as a large page.
- R3: Each read address is the table base plus index × entry size. The entry size is 8 bytes with the wide-entry flag set (rd_wide high) and 4 bytes otherwise, and then only the low 32 bits of rd_data are used. For read level L, counted from the top level down to 1, the index is taken from virtual address bit 12 + s·(L−1) upward, with s = 9 bits (wide) or 10 bits (narrow).
- R4: The first base is taken from CR3 as follows: bits 51:12 in four-level mode, bits 51:5 in three-level mode, and bits 31:12 in two-level mode. Each later base is the previous entry's bits 51:12 (wide) or bits 31:12 (narrow).
- R5: An entry with bit 0 clear ends the walk with ok low and pa zero.
- R6: A write access to an entry with bit 1 clear faults only when the write-protect input was set at start.
- R7: A user access to an entry with bit 2 clear faults.
- R8: With the wide-entry flag set, an execute access to an entry with bit 63 set faults.
- R9: In three-level mode the top pointer entry is checked only for bit 0. Its permission bits and bit 7 are ignored.
- R10: A present entry at read level 2 with bit 7 set, in a wide format, ends the walk with pa = {entry[51:21], va[20:0]}.
- R11: The same condition in the two-level format gives pa[39:32] = entry[20:13], pa[31:22] = entry[31:22] and pa[21:0] = va[21:0].
- R12: A walk ending at read level 1 gives pa = {entry[51:12], va[11:0]} (wide) or {entry[31:12], va[11:0]} (narrow).
- R13: err bit 1 records write, bit 2 user and bit 3 execute, set whenever a paged walk reads an entry. Bit 0 is set when a present entry at read level 1, or a present large-page entry, is reached, even if a permission fault follows.
- R14: After reset, done, ok, pa, err and rd_req are zero. A start is accepted only when idle, and inputs are captured at that point. Done is a single-cycle pulse, and ok/pa/err stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| va_i | input | VA_W | Virtual address to translate |
| acc_wr_i | input | 1 | Access is a write |
| acc_usr_i | input | 1 | Access is from user level |
| acc_exe_i | input | 1 | Access is an instruction fetch |
| cr3_i | input | 64 | Table root register |
| pg_en_i | input | 1 | Paging enabled |
| pae_i | input | 1 | Wide (8-byte) entry formats |
| lm_i | input | 1 | Four-level mode (with pae_i) |
| wp_i | input | 1 | Write-protect enforcement |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_addr_o | output | PA_W | Byte address of the entry |
| rd_wide_o | output | 1 | High for an 8-byte read, low for 4 bytes |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Entry returned by memory |
| done_o | output | 1 | Walk finished (one cycle) |
| ok_o | output | 1 | Translation succeeded |
| pa_o | output | PA_W | Physical address |
| err_o | output | 4 | Error code |

## Verification
The hardest case to reach is the three-level pointer entry that lacks user, write and execute permission but must still let the walk through, while the same entry in four-level mode must fault. Random tables almost never put that entry at the root address. The bench's memory model therefore makes every entry a hash of its address under a selectable bit policy. One policy strips permissions only within the 32 bytes at the computed root, and the bench drives virtual addresses whose top index lands there. The sweeps use other policies that force every entry present, or large, so that full-depth walks and large-page endings occur at every level in every mode.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        PW_IDLE  = 2'd0,
        PW_ISSUE = 2'd1,
        PW_WAIT  = 2'd2,
        PW_FIN   = 2'd3
    } pw_state_e;

    localparam int PW_ERR_W    = 4;
    localparam int PW_ERR_LEAF = 0;
    localparam int PW_ERR_WR   = 1;
    localparam int PW_ERR_USR  = 2;
    localparam int PW_ERR_EXE  = 3;

    // Entry bit positions used by the walker
    localparam int PW_B_PRESENT = 0;
    localparam int PW_B_WRITE   = 1;
    localparam int PW_B_USER    = 2;
    localparam int PW_B_LARGE   = 7;
    localparam int PW_B_NOEXEC  = 63;

    function automatic logic [63:0] pw_root_base(input logic [63:0] cr3,
                                                 input logic wide,
                                                 input logic lm);
        if (wide && lm)
            return {12'h0, cr3[51:12], 12'h0};
        else if (wide)
            return {12'h0, cr3[51:5], 5'h0};
        else
            return {32'h0, cr3[31:12], 12'h0};
    endfunction

    function automatic logic [63:0] pw_next_base(input logic [63:0] entry,
                                                 input logic wide);
        if (wide)
            return {12'h0, entry[51:12], 12'h0};
        else
            return {32'h0, entry[31:12], 12'h0};
    endfunction

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int VA_W  = 48,
    parameter int PA_W  = 52,
    parameter int LVL_W = 3
) (
    input  logic [PA_W-1:0]  base_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             wide_i,
    output logic [PA_W-1:0]  addr_o
);
    localparam int OFF_W = 13;

    logic [63:0]      va64;
    logic [63:0]      shifted;
    logic [5:0]       amt;
    logic [9:0]       idx;
    logic [OFF_W-1:0] off;

    assign va64 = {{(64 - VA_W){1'b0}}, va_i};

    always_comb begin
        int step;
        step    = wide_i ? 9 : 10;
        amt     = 6'(12 + step * (int'(lvl_i) - 1));
        shifted = va64 >> amt;
        idx     = wide_i ? {1'b0, shifted[8:0]} : shifted[9:0];
        off     = wide_i ? {idx, 3'b000} : {1'b0, idx, 2'b00};
    end

    assign addr_o = base_i + {{(PA_W - OFF_W){1'b0}}, off};

endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
    import pw_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic [63:0]      entry_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             wide_i,
    input  logic             lm_i,
    input  logic             wp_i,
    input  logic             wr_i,
    input  logic             usr_i,
    input  logic             exe_i,
    output logic             fault_o,
    output logic             large_o,
    output logic             leaf_o,
    output logic             page_hit_o
);
    logic present;
    logic ptr_level;
    logic perm_bad;

    assign present   = entry_i[PW_B_PRESENT];
    // three-level top pointer: presence only
    assign ptr_level = wide_i && !lm_i && (lvl_i == LVL_W'(3));

    assign large_o   = !ptr_level && (lvl_i == LVL_W'(2)) && entry_i[PW_B_LARGE];
    assign leaf_o    = large_o || (lvl_i == LVL_W'(1));
    assign page_hit_o = present && !ptr_level && leaf_o;

    assign perm_bad  = !ptr_level &&
                       ((wp_i && wr_i && !entry_i[PW_B_WRITE]) ||
                        (usr_i && !entry_i[PW_B_USER]) ||
                        (wide_i && exe_i && entry_i[PW_B_NOEXEC]));

    assign fault_o   = !present || perm_bad;

endmodule

// File: rtl/pw_pa_compose.sv
module pw_pa_compose #(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input  logic [63:0]     entry_i,
    input  logic [VA_W-1:0] va_i,
    input  logic            wide_i,
    input  logic            large_i,
    output logic [PA_W-1:0] pa_o
);
    logic [63:0] va64;
    logic [63:0] full;

    assign va64 = {{(64 - VA_W){1'b0}}, va_i};

    always_comb begin
        full = '0;
        if (large_i && wide_i) begin
            full = {12'h0, entry_i[51:21], va64[20:0]};
        end else if (large_i) begin
            full[39:32] = entry_i[20:13];
            full[31:22] = entry_i[31:22];
            full[21:0]  = va64[21:0];
        end else if (wide_i) begin
            full = {12'h0, entry_i[51:12], va64[11:0]};
        end else begin
            full = {32'h0, entry_i[31:12], va64[11:0]};
        end
    end

    assign pa_o = full[PA_W-1:0];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [VA_W-1:0]     va_i,
    input  logic                acc_wr_i,
    input  logic                acc_usr_i,
    input  logic                acc_exe_i,
    input  logic [63:0]         cr3_i,
    input  logic                pg_en_i,
    input  logic                pae_i,
    input  logic                lm_i,
    input  logic                wp_i,
    output logic                rd_req_o,
    output logic [PA_W-1:0]     rd_addr_o,
    output logic                rd_wide_o,
    input  logic                rd_valid_i,
    input  logic [63:0]         rd_data_i,
    output logic                done_o,
    output logic                ok_o,
    output logic [PA_W-1:0]     pa_o,
    output logic [PW_ERR_W-1:0] err_o
);
    localparam int LVL_W = 3;

    typedef struct packed {
        pw_state_e              st;
        logic [LVL_W-1:0]       lvl;
        logic [PA_W-1:0]        base;
        logic [VA_W-1:0]        va;
        logic                   wr;
        logic                   usr;
        logic                   exe;
        logic                   pg;
        logic                   wide;
        logic                   lm;
        logic                   wp;
        logic [PA_W-1:0]        pa;
        logic                   ok;
        logic [PW_ERR_W-1:0]    err;
    } walk_t;

    walk_t walk_q, walk_d;

    logic [63:0]         entry;
    logic [PA_W-1:0]     ent_addr;
    logic                chk_fault, chk_large, chk_leaf, chk_hit;
    logic [PA_W-1:0]     leaf_pa;
    logic [63:0]         root64, next64;
    logic [LVL_W-1:0]    top_lvl;
    logic [PA_W-1:0]     va_ext;
    logic [PW_ERR_W-1:0] acc_bits;

    assign entry   = walk_q.wide ? rd_data_i : {32'h0, rd_data_i[31:0]};
    assign root64  = pw_root_base(cr3_i, pae_i, lm_i);
    assign next64  = pw_next_base(entry, walk_q.wide);
    assign top_lvl = pae_i ? (lm_i ? LVL_W'(4) : LVL_W'(3)) : LVL_W'(2);
    assign va_ext  = {{(PA_W - VA_W){1'b0}}, va_i};

    always_comb begin
        acc_bits             = '0;
        acc_bits[PW_ERR_WR]  = walk_q.wr;
        acc_bits[PW_ERR_USR] = walk_q.usr;
        acc_bits[PW_ERR_EXE] = walk_q.exe;
        acc_bits[PW_ERR_LEAF] = chk_hit;
    end

    pw_entry_addr #(.VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W)) u_addr (
        .base_i (walk_q.base),
        .va_i   (walk_q.va),
        .lvl_i  (walk_q.lvl),
        .wide_i (walk_q.wide),
        .addr_o (ent_addr)
    );

    pw_entry_check #(.LVL_W(LVL_W)) u_check (
        .entry_i    (entry),
        .lvl_i      (walk_q.lvl),
        .wide_i     (walk_q.wide),
        .lm_i       (walk_q.lm),
        .wp_i       (walk_q.wp),
        .wr_i       (walk_q.wr),
        .usr_i      (walk_q.usr),
        .exe_i      (walk_q.exe),
        .fault_o    (chk_fault),
        .large_o    (chk_large),
        .leaf_o     (chk_leaf),
        .page_hit_o (chk_hit)
    );

    pw_pa_compose #(.VA_W(VA_W), .PA_W(PA_W)) u_compose (
        .entry_i (entry),
        .va_i    (walk_q.va),
        .wide_i  (walk_q.wide),
        .large_i (chk_large),
        .pa_o    (leaf_pa)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            PW_IDLE: begin
                if (start_i) begin
                    walk_d.va   = va_i;
                    walk_d.wr   = acc_wr_i;
                    walk_d.usr  = acc_usr_i;
                    walk_d.exe  = acc_exe_i;
                    walk_d.pg   = pg_en_i;
                    walk_d.wide = pae_i;
                    walk_d.lm   = pae_i & lm_i;
                    walk_d.wp   = wp_i;
                    walk_d.err  = '0;
                    walk_d.ok   = 1'b0;
                    walk_d.pa   = '0;
                    if (!pg_en_i) begin
                        walk_d.pa = va_ext;
                        walk_d.ok = 1'b1;
                        walk_d.st = PW_FIN;
                    end else begin
                        walk_d.lvl  = top_lvl;
                        walk_d.base = root64[PA_W-1:0];
                        walk_d.st   = PW_ISSUE;
                    end
                end
            end
            PW_ISSUE: walk_d.st = PW_WAIT;
            PW_WAIT: begin
                if (rd_valid_i) begin
                    walk_d.err = walk_q.err | acc_bits;
                    if (chk_fault) begin
                        walk_d.ok = 1'b0;
                        walk_d.pa = '0;
                        walk_d.st = PW_FIN;
                    end else if (chk_leaf) begin
                        walk_d.ok = 1'b1;
                        walk_d.pa = leaf_pa;
                        walk_d.st = PW_FIN;
                    end else begin
                        walk_d.lvl  = walk_q.lvl - LVL_W'(1);
                        walk_d.base = next64[PA_W-1:0];
                        walk_d.st   = PW_ISSUE;
                    end
                end
            end
            PW_FIN:  walk_d.st = PW_IDLE;
            default: walk_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign rd_req_o  = (walk_q.st == PW_ISSUE);
    assign rd_addr_o = ent_addr;
    assign rd_wide_o = walk_q.wide;
    assign done_o    = (walk_q.st == PW_FIN);
    assign ok_o      = walk_q.ok;
    assign pa_o      = walk_q.pa;
    assign err_o     = walk_q.err;

    // R14: done lasts exactly one cycle
    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R14: results held while idle without a start
    a_r14_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st == PW_IDLE && !start_i) |=>
            ($stable(pa_o) && $stable(ok_o) && $stable(err_o)));

    // R1: unpaged request finishes next cycle with success and no read
    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st == PW_IDLE && start_i && !pg_en_i) |=>
            (done_o && ok_o && !rd_req_o));

    // R5: absent entry ends the walk with a fault
    a_r5_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st == PW_WAIT && rd_valid_i && !entry[PW_B_PRESENT]) |=>
            (done_o && !ok_o));

    // R3: entry reads are aligned to the entry size
    a_r3_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_wide_o ? (rd_addr_o[2:0] == 3'b000)
                                : (rd_addr_o[1:0] == 2'b00)));

    // R2: one read outstanding at a time
    a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R13: a successful paged walk always reached a leaf entry
    a_r13_leaf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o && walk_q.pg) |-> err_o[PW_ERR_LEAF]);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int VA_W = 48;
    localparam int PA_W = 52;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [VA_W-1:0] va_i = '0;
    logic            acc_wr_i = 1'b0, acc_usr_i = 1'b0, acc_exe_i = 1'b0;
    logic [63:0]     cr3_i = '0;
    logic            pg_en_i = 1'b0, pae_i = 1'b0, lm_i = 1'b0, wp_i = 1'b0;
    logic            rd_req_o;
    logic [PA_W-1:0] rd_addr_o;
    logic            rd_wide_o;
    logic            rd_valid_i = 1'b0;
    logic [63:0]     rd_data_i = '0;
    logic            done_o, ok_o;
    logic [PA_W-1:0] pa_o;
    logic [3:0]      err_o;

    always #5 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .PA_W(PA_W)) dut (
        .clk, .rst_n, .start_i, .va_i, .acc_wr_i, .acc_usr_i, .acc_exe_i,
        .cr3_i, .pg_en_i, .pae_i, .lm_i, .wp_i, .rd_req_o, .rd_addr_o,
        .rd_wide_o, .rd_valid_i, .rd_data_i, .done_o, .ok_o, .pa_o, .err_o
    );

    int checks = 0, errors = 0, cycles = 0;
    int nreads = 0, wide_bad = 0, lat = 0, pol = 0;
    logic exp_wide = 1'b0;
    logic [51:0] top_base = '0;

    function automatic logic [63:0] mix(input logic [63:0] x);
        logic [63:0] z;
        z = x + 64'h9E3779B97F4A7C15;
        z = (z ^ (z >> 30)) * 64'hBF58476D1CE4E5B9;
        z = (z ^ (z >> 27)) * 64'h94D049BB133111EB;
        return z ^ (z >> 31);
    endfunction

    // entry content is a function of its address, shaped by the policy
    function automatic logic [63:0] ent(input logic [51:0] a);
        logic [63:0] h;
        h = mix({12'h0, a} ^ 64'h5BD1E995);
        case (pol)
            1: begin h[0] = 1; h[1] = 1; h[2] = 1; h[7] = 0; h[63] = 0; end
            2: begin h[0] = 1; h[1] = 1; h[2] = 1; h[7] = 1; h[63] = 0; end
            3: h[0] = 1;
            4: begin
                h[0] = 1; h[7] = 0;
                if (a >= top_base && a < top_base + 52'd32) begin
                    h[1] = 0; h[2] = 0; h[63] = 1;
                end else begin
                    h[1] = 1; h[2] = 1; h[63] = 0;
                end
            end
            default: ;
        endcase
        return h;
    endfunction

    // memory responder
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [51:0] addr_l = '0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        rd_valid_i <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= ent(addr_l);
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (rd_req_o) begin
            pend   <= 1'b1;
            addr_l <= rd_addr_o;
            cnt    <= lat;
            nreads <= nreads + 1;
            if (rd_wide_o !== exp_wide) wide_bad <= wide_bad + 1;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R14 watchdog expired act=%0d exp<=150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit good, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!good) begin
            errors = errors + 1;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic ref_walk(input logic [63:0] va, input logic w, u, x,
                            input logic [63:0] cr3,
                            input logic pg, pae, lm, wp,
                            output logic ok, output logic [51:0] pa,
                            output logic [3:0] err, output int nrd,
                            output string tag);
        int levels, bits, esz;
        logic [63:0] base, a, idx, e;
        logic lg;
        ok = 0; pa = '0; err = '0; nrd = 0; tag = "R1";
        if (!pg) begin
            ok = 1; pa = va[51:0];
            return;
        end
        levels = !pae ? 2 : (lm ? 4 : 3);
        bits   = pae ? 9 : 10;
        esz    = pae ? 8 : 4;
        if (!pae)    base = {32'h0, cr3[31:12], 12'h0};
        else if (lm) base = {12'h0, cr3[51:12], 12'h0};
        else         base = {12'h0, cr3[51:5], 5'h0};
        err = {x, u, w, 1'b0};
        for (int l = levels; l >= 1; l--) begin
            idx = (va >> (12 + bits * (l - 1))) & ((64'd1 << bits) - 1);
            a   = base + idx * 64'(esz);
            nrd++;
            e = ent(a[51:0]);
            if (!pae) e = {32'h0, e[31:0]};
            if (!e[0]) begin tag = "R5"; pa = '0; ok = 0; return; end
            if (pae && !lm && l == 3) begin
                base = {12'h0, e[51:12], 12'h0};
                continue;
            end
            lg = (l == 2) && e[7];
            if (lg || l == 1) err[0] = 1;
            if (wp && w && !e[1]) begin tag = "R6"; return; end
            if (u && !e[2])       begin tag = "R7"; return; end
            if (pae && x && e[63]) begin tag = "R8"; return; end
            if (lg) begin
                ok = 1;
                if (pae) begin
                    pa = {e[51:21], va[20:0]}; tag = "R10";
                end else begin
                    pa = '0; pa[39:32] = e[20:13]; pa[31:22] = e[31:22];
                    pa[21:0] = va[21:0]; tag = "R11";
                end
                return;
            end
            if (l == 1) begin
                ok = 1; tag = "R12";
                pa = pae ? {e[51:12], va[11:0]} : {20'h0, e[31:12], va[11:0]};
                return;
            end
            base = pae ? {12'h0, e[51:12], 12'h0} : {32'h0, e[31:12], 12'h0};
        end
    endtask

    task automatic run(input logic [63:0] va, input logic w, u, x,
                       input logic [63:0] cr3, input logic pg, pae, lm, wp,
                       input string note);
        logic eok; logic [51:0] epa; logic [3:0] eerr; int enrd; string tag;
        int r0, wb0, cyc;
        logic [51:0] hpa; logic hok; logic [3:0] herr;
        ref_walk(va, w, u, x, cr3, pg, pae, lm, wp, eok, epa, eerr, enrd, tag);
        tag = {tag, note};
        exp_wide = pae;
        @(negedge clk);
        va_i = va[VA_W-1:0]; acc_wr_i = w; acc_usr_i = u; acc_exe_i = x;
        cr3_i = cr3; pg_en_i = pg; pae_i = pae; lm_i = lm; wp_i = wp;
        start_i = 1'b1;
        r0 = nreads; wb0 = wide_bad;
        @(negedge clk);
        // R14: scrambled inputs and a second start while busy must be ignored
        va_i = ~va_i; acc_wr_i = ~w; acc_usr_i = ~u; acc_exe_i = ~x;
        cr3_i = ~cr3; pg_en_i = ~pg; pae_i = ~pae; lm_i = ~lm; wp_i = ~wp;
        start_i = 1'b1;
        cyc = 0;
        while (!done_o && cyc < 500) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(cyc < 500, "R14", "walk completes", 64'(cyc), 64'd500);
        check(ok_o == eok, tag, "ok", 64'(ok_o), 64'(eok));
        check(pa_o == epa, tag, "pa (R3,R4 addressing)", 64'(pa_o), 64'(epa));
        check(err_o == eerr, "R13", "err", 64'(err_o), 64'(eerr));
        check(nreads - r0 == enrd, "R2", "read count",
              64'(nreads - r0), 64'(enrd));
        check(wide_bad == wb0, "R3", "entry size", 64'(wide_bad - wb0), 64'd0);
        hpa = pa_o; hok = ok_o; herr = err_o;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R14", "done single cycle", 64'(done_o), 64'd0);
        repeat (2) @(negedge clk);
        check(pa_o == hpa && ok_o == hok && err_o == herr, "R14",
              "results held", 64'(pa_o), 64'(hpa));
    endtask

    initial begin
        logic [63:0] v, c;
        logic pae, lm;
        repeat (3) @(negedge clk);
        check(!done_o && !ok_o && !rd_req_o, "R14", "reset flags",
              {61'h0, done_o, ok_o, rd_req_o}, 64'd0);
        check(pa_o == '0 && err_o == '0, "R14", "reset results",
              64'(pa_o) | 64'(err_o), 64'd0);
        rst_n = 1'b1;

        // R1: paging disabled
        for (int k = 0; k < 8; k++) begin
            v = mix(64'(k) + 64'h100);
            run({16'h0, v[47:0]}, v[50], v[51], v[52], mix(v), 1'b0,
                v[53], v[54], v[55], " pass-through");
        end

        // R9: three-level pointer entry lacks permissions yet passes
        pol = 4; lat = 1;
        for (int k = 0; k < 4; k++) begin
            c = mix(64'(k) + 64'h200);
            top_base = {c[51:5], 5'h0};
            v = mix(64'(k) + 64'h300);
            run({32'h0, 2'(k), v[29:0]}, 1'b1, 1'b1, 1'b1, c,
                1'b1, 1'b1, 1'b0, 1'b1, " R9 pointer entry");
        end
        // R7: same entry kind at the four-level root faults
        for (int k = 0; k < 4; k++) begin
            c = mix(64'(k) + 64'h400);
            top_base = {c[51:12], 12'h0};
            v = mix(64'(k) + 64'h500);
            run({25'h0, v[38:0]}, 1'b0, 1'b1, 1'b0, c,
                1'b1, 1'b1, 1'b1, 1'b0, " R7 four-level root");
        end

        // sweeps over modes, entry policies, access kinds and write-protect
        for (int m = 0; m < 3; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int acc = 0; acc < 8; acc++) begin
                    for (int wpv = 0; wpv < 2; wpv++) begin
                        for (int k = 0; k < 8; k++) begin
                            pol = p; lat = k % 3;
                            v = mix(64'(((m * 4 + p) * 8 + acc) * 16 + wpv * 8 + k));
                            c = mix(v ^ 64'h1234);
                            pae = (m != 0); lm = (m == 2);
                            if (!lm) v = {32'h0, v[31:0]};
                            else     v = {16'h0, v[47:0]};
                            run(v, acc[0], acc[1], acc[2], c, 1'b1, pae, lm,
                                wpv[0], "");
                        end
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule